// File: doc/BRIEF.md
# Vectored Restart Interrupt Sequencer

This block runs interrupt entry and return for a small 8-bit processor with a 16-bit address space. It owns the program counter and the stack pointer. It watches eight request lines, each gated by its own mask bit. When it takes a request, it drops the instruction fetch at the current PC. In place of that instruction it performs a restart call: the PC is pushed, one byte per cycle, onto a stack in memory that grows downward. The PC is then loaded with the vector for the chosen level, which is eight times the level number.

A return strobe reverses the call. The saved PC is read back from the stack through the same byte-wide memory port, the stack pointer moves up by two, and the in-service bit is cleared. Only one level can be in service at a time. While a push or a pop is under way, a busy output tells the surrounding core to hold off.

Top module: `vri_seq`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0x0000 and the SP to 0xFFFF, and clears every mask bit and every in-service bit. Busy is low after reset.
- R2: In an idle cycle where no request is taken, `fetch_adv` high makes the PC increase by one at the clock edge.
- R3: `mask_we` loads `mask_in` into the mask register at the clock edge. A level whose mask bit is 1 is never taken.
- R4: In an idle cycle with no level in service, if any unmasked request is high, `take` is high in that same cycle and the lowest-numbered such level is chosen. The fetch in that cycle is discarded: the PC does not advance.
- R5: The push uses two write cycles right after the take, with `busy` high in both. The first cycle writes PC[15:8] at SP-1. The second writes PC[7:0] at SP-2.
- R6: At the end of the push, SP equals the old SP minus 2, the PC equals 8 times the taken level, and only in-service bit n is set (bit n of `svc`).
- R7: At most one in-service bit is set. While any bit is set, no request is taken.
- R8: A `ret_strobe` in an idle cycle with a level in service starts a pop. The pop reads at SP in the first cycle and at SP+1 in the second. Read data is expected on `mem_rdata` one cycle after each read. One further busy cycle follows. Then the PC equals {byte at SP+1, byte at SP}, SP has risen by 2, and `svc` is zero.
- R9: A `ret_strobe` while no level is in service has no effect: no read, no busy, and PC, SP and `svc` stay unchanged.
- R10: `mem_we` and `mem_re` are never high together, and both are low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 8 | Interrupt request lines, bit n is level n |
| mask_we | input | 1 | Load strobe for the mask register |
| mask_in | input | 8 | New mask value, 1 blocks the level |
| fetch_adv | input | 1 | Instruction fetch consumed, advance PC |
| ret_strobe | input | 1 | Return from the service routine |
| mem_rdata | input | 8 | Read data, valid one cycle after a read |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | Push or pop sequence in progress |
| take | output | 1 | Request taken this cycle, fetch discarded |
| svc | output | 8 | In-service bits |

## Verification
Some behaviours are checked by assertions on every cycle. The port never reads and writes in the same cycle, and it is quiet when idle. `svc` is one-hot or zero, and nothing is taken while a level is in service. The first push write follows every take with the right address and byte. No masked level ever lands in service, and SP rises by two when service ends. Other behaviours need the bench's scenarios: the lowest-level priority over random request and mask patterns, the exact vector loaded into the PC, the return address rebuilt from bytes placed in the bench memory, and a stray return being ignored.

// File: rtl/vri_pkg.sv
package vri_pkg;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PUSH_HI,
        SQ_PUSH_LO,
        SQ_POP_LO,
        SQ_POP_HI,
        SQ_POP_FIN
    } seq_st_t;

    typedef struct packed {
        logic  we;
        logic  re;
        addr_t addr;
        byte_t wdata;
    } mem_req_t;

    function automatic addr_t vec_of(input int unsigned lvl, input int unsigned step);
        return addr_t'(lvl * step);
    endfunction

endpackage

// File: rtl/vri_arb.sv
module vri_arb #(
    parameter int NLEV = 8,
    localparam int LW = (NLEV > 1) ? $clog2(NLEV) : 1
) (
    input  logic [NLEV-1:0] req,
    input  logic [NLEV-1:0] mask,
    output logic            hit,
    output logic [LW-1:0]   lvl
);
    logic [NLEV-1:0] elig;
    assign elig = req & ~mask;

    always_comb begin
        hit = 1'b0;
        lvl = '0;
        for (int i = NLEV - 1; i >= 0; i--) begin
            if (elig[i]) begin
                hit = 1'b1;
                lvl = LW'(i);
            end
        end
    end
endmodule

// File: rtl/vri_ctl.sv
module vri_ctl
    import vri_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    hit,
    input  logic    svc_any,
    input  logic    ret_in,
    output seq_st_t st,
    output logic    take,
    output logic    busy
);
    seq_st_t st_nx;
    logic    ret_go;

    assign take   = (st == SQ_IDLE) && hit && !svc_any;
    assign ret_go = (st == SQ_IDLE) && ret_in && svc_any;
    assign busy   = (st != SQ_IDLE);

    always_comb begin
        st_nx = st;
        unique case (st)
            SQ_IDLE: begin
                if (take)        st_nx = SQ_PUSH_HI;
                else if (ret_go) st_nx = SQ_POP_LO;
            end
            SQ_PUSH_HI: st_nx = SQ_PUSH_LO;
            SQ_PUSH_LO: st_nx = SQ_IDLE;
            SQ_POP_LO:  st_nx = SQ_POP_HI;
            SQ_POP_HI:  st_nx = SQ_POP_FIN;
            SQ_POP_FIN: st_nx = SQ_IDLE;
            default:    st_nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= SQ_IDLE;
        else     st <= st_nx;
    end
endmodule

// File: rtl/vri_ptr.sv
module vri_ptr
    import vri_pkg::*;
#(
    parameter int    NLEV    = 8,
    parameter int    VSTEP   = 8,
    parameter addr_t SP_INIT = '1,
    localparam int LW = (NLEV > 1) ? $clog2(NLEV) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_st_t       st,
    input  logic          take,
    input  logic [LW-1:0] lvl,
    input  logic          fetch_adv,
    input  byte_t         rdata,
    output addr_t         pc,
    output addr_t         sp,
    output mem_req_t      mreq
);
    logic [LW-1:0] lvl_q;
    byte_t         lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= '0;
            sp    <= SP_INIT;
            lvl_q <= '0;
            lo_q  <= '0;
        end else begin
            unique case (st)
                SQ_IDLE: begin
                    if (take)           lvl_q <= lvl;
                    else if (fetch_adv) pc <= pc + addr_t'(1);
                end
                SQ_PUSH_LO: begin
                    sp <= sp - addr_t'(2);
                    pc <= vec_of(int'(lvl_q), VSTEP);
                end
                SQ_POP_HI:  lo_q <= rdata;
                SQ_POP_FIN: begin
                    pc <= {rdata, lo_q};
                    sp <= sp + addr_t'(2);
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mreq = '0;
        unique case (st)
            SQ_PUSH_HI: begin
                mreq.we    = 1'b1;
                mreq.addr  = sp - addr_t'(1);
                mreq.wdata = pc[ADDR_W-1:BYTE_W];
            end
            SQ_PUSH_LO: begin
                mreq.we    = 1'b1;
                mreq.addr  = sp - addr_t'(2);
                mreq.wdata = pc[BYTE_W-1:0];
            end
            SQ_POP_LO: begin
                mreq.re   = 1'b1;
                mreq.addr = sp;
            end
            SQ_POP_HI: begin
                mreq.re   = 1'b1;
                mreq.addr = sp + addr_t'(1);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vri_seq.sv
module vri_seq
    import vri_pkg::*;
#(
    parameter int NLEV  = 8,
    parameter int VSTEP = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLEV-1:0]   irq_req,
    input  logic              mask_we,
    input  logic [NLEV-1:0]   mask_in,
    input  logic              fetch_adv,
    input  logic              ret_strobe,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] sp,
    output logic              busy,
    output logic              take,
    output logic [NLEV-1:0]   svc
);
    localparam int LW = (NLEV > 1) ? $clog2(NLEV) : 1;

    logic [NLEV-1:0] mask_q;
    logic [NLEV-1:0] svc_q;
    logic            hit;
    logic [LW-1:0]   lvl;
    seq_st_t         st;
    mem_req_t        mreq;

    vri_arb #(.NLEV(NLEV)) u_arb (
        .req  (irq_req),
        .mask (mask_q),
        .hit  (hit),
        .lvl  (lvl)
    );

    vri_ctl u_ctl (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit),
        .svc_any (|svc_q),
        .ret_in  (ret_strobe),
        .st      (st),
        .take    (take),
        .busy    (busy)
    );

    vri_ptr #(.NLEV(NLEV), .VSTEP(VSTEP), .SP_INIT('1)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .st        (st),
        .take      (take),
        .lvl       (lvl),
        .fetch_adv (fetch_adv),
        .rdata     (mem_rdata),
        .pc        (pc),
        .sp        (sp),
        .mreq      (mreq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            svc_q  <= '0;
        end else begin
            if (mask_we) mask_q <= mask_in;
            if (take)                  svc_q <= NLEV'(1) << lvl;
            else if (st == SQ_POP_FIN) svc_q <= '0;
        end
    end

    assign svc       = svc_q;
    assign mem_we    = mreq.we;
    assign mem_re    = mreq.re;
    assign mem_addr  = mreq.addr;
    assign mem_wdata = mreq.wdata;
endmodule

// File: rtl/vri_seq_chk.sv
module vri_seq_chk #(
    parameter int NLEV = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            mem_we,
    input logic            mem_re,
    input logic [15:0]     mem_addr,
    input logic [7:0]      mem_wdata,
    input logic [15:0]     pc,
    input logic [15:0]     sp,
    input logic            busy,
    input logic            take,
    input logic [NLEV-1:0] svc,
    input logic [NLEV-1:0] mask_q
);
    // R1
    rst_state_chk: assert property (@(posedge clk)
        rst |=> (pc == 16'h0000 && sp == 16'hFFFF && svc == '0 && !busy));

    // R10
    rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_we && !mem_re));

    // R7
    svc_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(svc));

    // R7
    no_nest_chk: assert property (@(posedge clk) disable iff (rst)
        (svc != '0) |-> !take);

    // R5
    push_hi_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (busy && mem_we && mem_addr == $past(sp) - 16'd1
                  && mem_wdata == $past(pc[15:8])));

    // R3
    masked_out_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> ($onehot(svc) && ((svc & $past(mask_q)) == '0)));

    // R8
    pop_sp_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(|svc) |-> (sp == $past(sp) + 16'd2));
endmodule

bind vri_seq vri_seq_chk #(.NLEV(NLEV)) u_vri_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .pc        (pc),
    .sp        (sp),
    .busy      (busy),
    .take      (take),
    .svc       (svc),
    .mask_q    (mask_q)
);

// File: tb/vri_seq_tb.sv
module vri_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  irq_req = '0;
    logic        mask_we = 1'b0;
    logic [7:0]  mask_in = '0;
    logic        fetch_adv = 1'b0;
    logic        ret_strobe = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        mem_we, mem_re, busy, take;
    logic [15:0] mem_addr, pc, sp;
    logic [7:0]  mem_wdata, svc;

    logic [7:0]  mem [0:255];
    int          total = 0;
    int          bad = 0;
    logic [15:0] pc_m, sp_m;
    logic [7:0]  mask_m, svc_m;

    always #2.5 clk = ~clk;

    vri_seq u_dut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .mask_we(mask_we),
        .mask_in(mask_in), .fetch_adv(fetch_adv), .ret_strobe(ret_strobe),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pc(pc), .sp(sp),
        .busy(busy), .take(take), .svc(svc)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int lowest(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic set_mask(input logic [7:0] m);
        @(negedge clk); mask_we = 1'b1; mask_in = m;
        @(negedge clk); mask_we = 1'b0; mask_m = m;
    endtask

    task automatic advance(input int n);
        @(negedge clk); fetch_adv = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pc_m = pc_m + 16'd1;
        end
        fetch_adv = 1'b0;
        chk("R2 pc after fetches", pc, pc_m);
    endtask

    task automatic do_entry(input logic [7:0] req);
        logic [7:0] elig;
        logic       go;
        int         lv;
        logic [7:0] hi, lo;
        elig = req & ~mask_m;
        go   = (elig != 0) && (svc_m == 0);
        lv   = lowest(elig);
        @(negedge clk); irq_req = req; fetch_adv = 1'b1; #1;
        chk("R4 take", take, go);
        if (!go) begin
            @(negedge clk); irq_req = '0; fetch_adv = 1'b0;
            pc_m = pc_m + 16'd1;
            chk("R2 R3 R7 pc advanced, no take", pc, pc_m);
            chk("R7 busy stays low", busy, 1'b0);
            chk("R7 svc unchanged", svc, svc_m);
        end else begin
            hi = pc_m[15:8]; lo = pc_m[7:0];
            @(negedge clk); irq_req = '0;
            chk("R5 busy hi", busy, 1'b1);
            chk("R5 we hi", mem_we, 1'b1);
            chk("R5 addr hi", mem_addr, sp_m - 16'd1);
            chk("R5 data hi", mem_wdata, hi);
            @(negedge clk);
            chk("R5 busy lo", busy, 1'b1);
            chk("R5 addr lo", mem_addr, sp_m - 16'd2);
            chk("R5 data lo", mem_wdata, lo);
            @(negedge clk); fetch_adv = 1'b0;
            chk("R5 stacked hi", mem[8'(sp_m - 16'd1)], hi);
            chk("R5 stacked lo", mem[8'(sp_m - 16'd2)], lo);
            sp_m  = sp_m - 16'd2;
            pc_m  = 16'(lv * 8);
            svc_m = 8'd1 << lv;
            chk("R4 R6 vector pc", pc, pc_m);
            chk("R6 sp", sp, sp_m);
            chk("R6 svc", svc, svc_m);
            chk("R6 busy done", busy, 1'b0);
        end
    endtask

    task automatic do_ret(input logic [15:0] np);
        logic go;
        go = (svc_m != 0);
        if (go) begin
            mem[sp_m[7:0]]          = np[7:0];
            mem[8'(sp_m + 16'd1)]   = np[15:8];
        end
        @(negedge clk); ret_strobe = 1'b1;
        @(negedge clk); ret_strobe = 1'b0;
        if (go) begin
            chk("R8 re first", mem_re, 1'b1);
            chk("R8 addr first", mem_addr, sp_m);
            @(negedge clk);
            chk("R8 re second", mem_re, 1'b1);
            chk("R8 addr second", mem_addr, sp_m + 16'd1);
            @(negedge clk);
            chk("R8 busy final", busy, 1'b1);
            chk("R10 no access final", {mem_we, mem_re}, 2'b00);
            @(negedge clk);
            sp_m = sp_m + 16'd2; pc_m = np; svc_m = '0;
            chk("R8 pc restored", pc, pc_m);
            chk("R8 sp", sp, sp_m);
            chk("R8 svc cleared", svc, 8'h00);
            chk("R8 busy done", busy, 1'b0);
        end else begin
            chk("R9 no read", mem_re, 1'b0);
            chk("R9 no busy", busy, 1'b0);
            @(negedge clk);
            chk("R9 pc", pc, pc_m);
            chk("R9 sp", sp, sp_m);
            chk("R9 svc", svc, svc_m);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0]  r;
        logic [15:0] np;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        pc_m = 16'h0000; sp_m = 16'hFFFF; mask_m = '0; svc_m = '0;
        chk("R1 pc", pc, 16'h0000);
        chk("R1 sp", sp, 16'hFFFF);
        chk("R1 svc", svc, 8'h00);
        chk("R1 busy", busy, 1'b0);

        advance(5);
        do_ret(16'h1234);                  // R9 stray return
        do_entry(8'hFF);                   // R4 lowest wins: level 0
        do_entry(8'h10);                   // R7 blocked while in service
        do_ret(16'h0ABC);                  // R8
        set_mask(8'h7F);                   // R3 only level 7 open
        do_entry(8'h7F);                   // R3 all masked
        do_entry(8'hC0);                   // level 7, vector 56
        do_ret(16'hFEDC);
        set_mask(8'h00);
        do_entry(8'h24);                   // R4 level 2
        do_ret(16'h8001);

        for (int k = 0; k < 40; k++) begin
            if ($urandom % 3 == 0) set_mask(8'($urandom));
            if ($urandom % 2 == 0) advance(1 + ($urandom % 4));
            r = 8'($urandom);
            do_entry(r);
            np = 16'($urandom);
            do_ret(np);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule